// File: doc/BRIEF.md
# Chip-Enable-Timed Static RAM Write Sequencer

This block sits between synchronous logic and an external asynchronous static RAM of 512K words by 8 bits. It turns a one-cycle write request into a full write cycle in which chip enable opens and closes the write window. The requester presents an address and a data byte with a valid strobe while `ready` is high. The block then registers both and places them on the memory pins. It drops write enable first and opens the window by pulling chip enable low. It closes the window by releasing chip enable, releases write enable one cycle later, and pads the cycle out to the memory's minimum cycle time before it reports completion.

Each timing minimum (address setup, chip-enable width, address-valid-to-end, data setup, write pulse, total cycle) is given as a picosecond parameter. It is turned into a whole number of clock cycles at elaboration, so the same RTL serves any speed grade and any clock. Output enable stays inactive for all time, and the data driver is enabled only while the write is under way.

Top module: `sramCeWriter`

## Requirements
- R1: While reset is asserted and after it is released, `memCeN`, `memWeN` and `memOeN` are high, `memDqEn` is low, `ready` is high and `done` is low.
- R2: A request (`reqValid` high while `ready` is high) is captured on that clock edge. For the next S cycles the captured address and data are on the pins, `memDqEn` is high, `memWeN` is low and `memCeN` is high.
- R3: After the setup cycles, `memCeN` is low for exactly W consecutive cycles. It is only ever low while `memWeN` has already been low for at least one cycle.
- R4: In the cycle after the window, `memCeN` is high while `memWeN` is still low and the bus is still driven. `memWeN` only rises after `memCeN` has been high for a cycle.
- R5: Then follow R recovery cycles with `memCeN` and `memWeN` high and the bus released, so that S+W+1+R is at least the cycle-time count.
- R6: `done` is high for exactly one cycle, in the first cycle after recovery. `ready` is high in that same cycle.
- R7: `ready` is low from the cycle after a request is accepted until recovery ends. A `reqValid` raised in that time is ignored: it starts no write and changes neither the address nor the data on the pins.
- R8: `memOeN` is high in every cycle.
- R9: `memDqEn` is high exactly in the setup, window and closing cycles and low in every other cycle.
- R10: `memAddr` and `memDqOut` keep the captured values from the first setup cycle until the next accepted request.
- R11: Each cycle count is computed as ceil(ps / CLK_PERIOD_PS), with a minimum of 1. S is the address-setup count. W is the largest of the chip-enable, address-valid, data-setup and write-pulse counts. R is the cycle-time count minus (S+W+1), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request strobe |
| reqAddr | input | 19 | Word address of the request |
| reqData | input | 8 | Byte to write |
| ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle completion pulse |
| memAddr | output | 19 | Address pins of the memory |
| memDqOut | output | 8 | Value for the data pins |
| memDqEn | output | 1 | Data pin driver enable (high drives, low is high impedance) |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low, held inactive |

## Verification
A wrong sequencer state shows at the pins in the very cycle it is entered, because every strobe is decoded directly from the state register. A stray transition shows up at once: chip enable falls without write enable already low, write enable rises together with chip enable, or the driver enable covers the wrong cycles. A count register loaded with the wrong value shows up later, as a window or recovery that is one or more cycles too short or too long. This is seen at the rising edge of chip enable, or at the `done` pulse that arrives early or late by the same number of cycles. A capture register that reloads while busy shows up as the address or data pins changing between the setup cycle and `done`.

// File: rtl/sramCeWriterPkg.sv
package sramCeWriterPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WINDOW,
    ST_CLOSE,
    ST_RECOVER
  } wrState_t;

  // Strobes from the sequencer to the pin datapath.
  typedef struct packed {
    logic load;    // capture address and data
    logic drive;   // enable the data pin driver
    logic weLow;   // assert write enable
    logic ceLow;   // assert chip enable
  } wrStrobe_t;

  // Whole cycles covering a picosecond minimum, never fewer than one.
  function automatic int cycCount(input int ps, input int periodPs);
    int c;
    c = (ps + periodPs - 1) / periodPs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Padding after the closing cycle so the whole cycle meets the cycle time.
  function automatic int recCount(input int wcCyc, input int usedCyc);
    int r;
    r = wcCyc - usedCyc;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/sramCeWrCtrl.sv
module sramCeWrCtrl
  import sramCeWriterPkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WIN_CYC   = 2,
  parameter int REC_CYC   = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output wrStrobe_t strobe,
  output logic      ready,
  output logic      done
);

  localparam int MAX_CYC = maxOf4(SETUP_CYC, WIN_CYC, REC_CYC, 1);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  wrState_t   state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state <= ST_SETUP;
            cnt   <= CNT_W'(SETUP_CYC - 1);
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_WINDOW;
            cnt   <= CNT_W'(WIN_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WINDOW: begin
          if (cnt == '0) begin
            state <= ST_CLOSE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CLOSE: begin
          state <= ST_RECOVER;
          cnt   <= CNT_W'(REC_CYC - 1);
        end
        ST_RECOVER: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic busyDrive;
  assign busyDrive = (state == ST_SETUP) || (state == ST_WINDOW) || (state == ST_CLOSE);

  always_comb begin
    strobe.load  = (state == ST_IDLE) && reqValid;
    strobe.drive = busyDrive;
    strobe.weLow = busyDrive;
    strobe.ceLow = (state == ST_WINDOW);
  end

  assign ready = (state == ST_IDLE);

endmodule

// File: rtl/sramCeWrPath.sv
module sramCeWrPath
  import sramCeWriterPkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqEn,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobe.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = dataQ;
  assign memDqEn  = strobe.drive;
  assign memCeN   = ~strobe.ceLow;
  assign memWeN   = ~strobe.weLow;
  assign memOeN   = 1'b1;

endmodule

// File: rtl/sramCeWriter.sv
module sramCeWriter
  import sramCeWriterPkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_AS_PS       = 0,
  parameter int T_CW_PS       = 10000,
  parameter int T_AW_PS       = 10000,
  parameter int T_DS_PS       = 6000,
  parameter int T_WP_PS       = 8000,
  parameter int T_WC_PS       = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              ready,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqEn,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN
);

  localparam int SETUP_CYC = cycCount(T_AS_PS, CLK_PERIOD_PS);
  localparam int WIN_CYC   = maxOf4(cycCount(T_CW_PS, CLK_PERIOD_PS),
                                    cycCount(T_AW_PS, CLK_PERIOD_PS),
                                    cycCount(T_DS_PS, CLK_PERIOD_PS),
                                    cycCount(T_WP_PS, CLK_PERIOD_PS));
  localparam int WC_CYC    = cycCount(T_WC_PS, CLK_PERIOD_PS);
  localparam int REC_CYC   = recCount(WC_CYC, SETUP_CYC + WIN_CYC + 1);

  wrStrobe_t strobe;

  sramCeWrCtrl #(
    .SETUP_CYC(SETUP_CYC),
    .WIN_CYC  (WIN_CYC),
    .REC_CYC  (REC_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobe  (strobe),
    .ready   (ready),
    .done    (done)
  );

  sramCeWrPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqData (reqData),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .memDqEn (memDqEn),
    .memCeN  (memCeN),
    .memWeN  (memWeN),
    .memOeN  (memOeN)
  );

endmodule

// File: rtl/sramCeWriterChk.sv
module sramCeWriterChk #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int MIN_WIN = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqEn,
  input logic              memCeN,
  input logic              memWeN
);

  // Length of the current chip-enable-low run.
  int ceLowRun;
  always_ff @(posedge clk) begin
    if (!rstN)        ceLowRun <= 0;
    else if (!memCeN) ceLowRun <= ceLowRun + 1;
    else              ceLowRun <= 0;
  end

  assert_we_leads_ce_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCeN) |-> $past(!memWeN));

  assert_ce_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCeN) |-> (ceLowRun >= MIN_WIN));

  assert_we_trails_ce_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> ($past(memCeN) && memCeN));

  assert_bus_covers_we_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqEn);

  assert_pins_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDqOut)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);

  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !ready);

endmodule

bind sramCeWriter sramCeWriterChk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .MIN_WIN(WIN_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ready   (ready),
  .done    (done),
  .memAddr (memAddr),
  .memDqOut(memDqOut),
  .memDqEn (memDqEn),
  .memCeN  (memCeN),
  .memWeN  (memWeN)
);

// File: tb/tb_sramCeWriter.sv
`timescale 1ns/1ps
module tb_sramCeWriter;

  localparam int PERIOD_PS = 8000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValidA = 1'b0;
  logic        reqValidB = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqData = '0;

  logic        readyA, doneA, dqEnA, ceNA, weNA, oeNA;
  logic [18:0] addrA;
  logic [7:0]  dataA;
  logic        readyB, doneB, dqEnB, ceNB, weNB, oeNB;
  logic [18:0] addrB;
  logic [7:0]  dataB;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  sramCeWriter dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValidA), .reqAddr(reqAddr), .reqData(reqData),
    .ready(readyA), .done(doneA), .memAddr(addrA), .memDqOut(dataA), .memDqEn(dqEnA),
    .memCeN(ceNA), .memWeN(weNA), .memOeN(oeNA)
  );

  sramCeWriter #(.T_CW_PS(20000), .T_WC_PS(60000)) dutSlow (
    .clk(clk), .rstN(rstN), .reqValid(reqValidB), .reqAddr(reqAddr), .reqData(reqData),
    .ready(readyB), .done(doneB), .memAddr(addrB), .memDqOut(dataB), .memDqEn(dqEnB),
    .memCeN(ceNB), .memWeN(weNB), .memOeN(oeNB)
  );

  // Observation vector: {ready, done, ceN, weN, oeN, dqEn, addr[18:0], data[7:0]}
  logic [32:0] obsA, obsB;
  assign obsA = {readyA, doneA, ceNA, weNA, oeNA, dqEnA, addrA, dataA};
  assign obsB = {readyB, doneB, ceNB, weNB, oeNB, dqEnB, addrB, dataB};

  function automatic int cyc(input int ps);
    int c;
    c = (ps + PERIOD_PS - 1) / PERIOD_PS;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic checkIdle(input bit slow, input string tag);
    logic [32:0] o;
    o = slow ? obsB : obsA;
    checkEq(tag, "ready", int'(o[32]), 1);
    checkEq(tag, "done", int'(o[31]), 0);
    checkEq(tag, "ceN", int'(o[30]), 1);
    checkEq(tag, "weN", int'(o[29]), 1);
    checkEq(tag, "oeN", int'(o[28]), 1);
    checkEq(tag, "dqEn", int'(o[27]), 0);
  endtask

  // One write from request to two cycles past completion; optional poke while busy.
  task automatic runWrite(input bit slow, input logic [18:0] a, input logic [7:0] d,
                          input bit poke, input int s, input int w, input int r);
    int t;
    int weCnt;
    logic [32:0] o;
    string ph;
    t = s + w + 1 + r;
    weCnt = 0;
    @(negedge clk);
    reqAddr = a;
    reqData = d;
    if (slow) reqValidB = 1'b1; else reqValidA = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= t + 2; k++) begin
      @(negedge clk);
      o = slow ? obsB : obsA;
      if (k <= s)              ph = "R2";
      else if (k <= s + w)     ph = "R3";
      else if (k == s + w + 1) ph = "R4";
      else if (k <= t)         ph = "R5";
      else                     ph = "R6";
      if (!o[29]) weCnt++;
      checkEq(ph, "ceN", int'(o[30]), (k > s && k <= s + w) ? 0 : 1);
      checkEq(ph, "weN", int'(o[29]), (k <= s + w + 1) ? 0 : 1);
      checkEq("R9", "dqEn", int'(o[27]), (k <= s + w + 1) ? 1 : 0);
      checkEq("R8", "oeN", int'(o[28]), 1);
      checkEq("R7", "ready", int'(o[32]), (k <= t) ? 0 : 1);
      checkEq("R6", "done", int'(o[31]), (k == t + 1) ? 1 : 0);
      checkEq("R10", "addr", int'(o[26:8]), int'(a));
      checkEq("R10", "data", int'(o[7:0]), int'(d));
      if (k == 1) begin
        reqValidA = 1'b0;
        reqValidB = 1'b0;
      end
      if (poke && k == 2) begin
        reqAddr = a ^ 19'h5A5A5;
        reqData = ~d;
        if (slow) reqValidB = 1'b1; else reqValidA = 1'b1;
      end
      if (poke && k == t) begin
        reqValidA = 1'b0;
        reqValidB = 1'b0;
      end
    end
    checkEq("R11", "we-low cycles", weCnt, s + w + 1);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        checkIdle(slow, "R7");
        o = slow ? obsB : obsA;
        checkEq("R7", "addr after ignored request", int'(o[26:8]), int'(a));
        checkEq("R7", "data after ignored request", int'(o[7:0]), int'(d));
      end
    end
  endtask

  int sA, wA, rA, sB, wB, rB;

  task automatic testReset();
    @(negedge clk);
    checkIdle(1'b0, "R1");
    checkIdle(1'b1, "R1");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle(1'b0, "R1");
    checkIdle(1'b1, "R1");
  endtask

  task automatic testBasic();
    runWrite(1'b0, 19'h7FFFF, 8'hA5, 1'b0, sA, wA, rA);
    runWrite(1'b0, 19'h00000, 8'h00, 1'b0, sA, wA, rA);
    runWrite(1'b0, 19'h2B3C4, 8'h5A, 1'b0, sA, wA, rA);
  endtask

  task automatic testIgnoreBusy();
    runWrite(1'b0, 19'h12345, 8'h3C, 1'b1, sA, wA, rA);
  endtask

  task automatic testSlowGrade();
    runWrite(1'b1, 19'h40001, 8'hC3, 1'b0, sB, wB, rB);
    runWrite(1'b1, 19'h0F0F0, 8'h81, 1'b1, sB, wB, rB);
    checkEq("R5", "slow cycle meets cycle time", sB + wB + 1 + rB, cyc(60000));
  endtask

  initial begin
    int wc;
    sA = cyc(0);
    wA = cyc(10000);
    if (cyc(6000) > wA) wA = cyc(6000);
    if (cyc(8000) > wA) wA = cyc(8000);
    wc = cyc(10000) - (sA + wA + 1);
    rA = (wc < 1) ? 1 : wc;
    sB = cyc(0);
    wB = cyc(20000);
    if (cyc(10000) > wB) wB = cyc(10000);
    wc = cyc(60000) - (sB + wB + 1);
    rB = (wc < 1) ? 1 : wc;

    testReset();
    testBasic();
    testIgnoreBusy();
    testSlowGrade();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #400000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not finish, actual hung expected complete");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule